// File: doc/BRIEF.md
# Load-Use and Branch Hazard Controller

This block holds the front of a five-stage in-order pipeline: the program counter, the fetch/decode pipeline register and the control half of the decode/execute register. It decides, every cycle, whether the front of the pipeline may advance. When the instruction in execute is a memory read whose target register is a source of the instruction in decode, it freezes the program counter and the fetch/decode register for one cycle. In that same cycle it sends an all-zero control word into execute, so the hole travels down the pipe as a no-op.

Branches are resolved in decode. An external register file, with its forwarding, supplies the two operand values, and the main decoder supplies the branch kind. Fetch always proceeds sequentially, which amounts to a static not-taken guess. When a branch in decode turns out to be taken, the program counter loads the target. The target is the branch's incremented PC plus its sign-extended offset scaled by the step size. The wrongly fetched instruction in the fetch/decode register is replaced by all zeros, costing one cycle.

A load-use stall outranks a taken branch in the same cycle. The branch is simply evaluated again on the next cycle, once its operands are valid.

Top module: `pipe_hazard_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the PC loads `RESET_PC` (0 by default), and the fetch/decode instruction, its PC copy, the execute control word and the execute Rt are all cleared to zero.
- R2: In a cycle with no stall and no taken branch, the PC advances by `PC_STEP` (4). The fetch/decode register captures `fetch_instr_i` together with the old PC plus `PC_STEP`.
- R3: A load-use stall is raised when the execute control word has its memory-read bit (bit 5) set and `ex_rt_o` equals the decode Rs field (instruction bits 25:21) or the decode Rt field (bits 20:16). During the stall, `pc_we_o` and `ifid_we_o` are 0 and `bubble_o` is 1, all in the same cycle.
- R4: On a stall edge, the PC and the fetch/decode register keep their values and the execute control word is loaded with all zeros. A single load followed by a dependent instruction costs exactly one stall cycle.
- R5: No stall is raised when the execute instruction does not read memory, even if its Rt matches. No stall is raised for a memory read whose Rt matches neither decode source.
- R6: The branch kind `dec_br_kind_i` is coded 00 none, 01 taken-if-equal, 10 taken-if-not-equal and 11 reserved (never taken). The compare uses `dec_opa_i` and `dec_opb_i`.
- R7: For a taken branch with no stall, `flush_o` is 1. At the edge, the PC loads `dec_pc4_o` plus the sign-extended offset (bits 15:0) times `PC_STEP`, and the fetch/decode instruction and PC copy become zero.
- R8: An untaken branch has no effect on the fetch path: the PC and the fetch/decode register advance as in R2.
- R9: When a stall and a taken branch coincide, the stall wins: `flush_o` is 0, and the PC and the fetch/decode register hold.
- R10: The control word has the layout [8] mem-to-reg, [7] reg-write, [6] branch, [5] mem-read, [4] mem-write, [3] reg-dst, [2:1] ALU op, [0] ALU source. Outside a bubble, it passes unchanged from `dec_ctl_i` to `ex_ctl_o` at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_instr_i | input | INSTR_W | Instruction read at the current PC |
| dec_ctl_i | input | 9 | Control word decoded from the instruction in decode |
| dec_br_kind_i | input | 2 | Branch kind of the instruction in decode |
| dec_opa_i | input | DATA_W | First compare operand of the decode instruction |
| dec_opb_i | input | DATA_W | Second compare operand of the decode instruction |
| pc_o | output | ADDR_W | Program counter |
| dec_instr_o | output | INSTR_W | Instruction held in the fetch/decode register |
| dec_pc4_o | output | ADDR_W | Incremented PC held with that instruction |
| ex_ctl_o | output | 9 | Control word in the decode/execute register |
| ex_rt_o | output | REG_W | Rt field of the instruction in execute |
| pc_we_o | output | 1 | PC write enable for this cycle |
| ifid_we_o | output | 1 | Fetch/decode register write enable for this cycle |
| bubble_o | output | 1 | Zero control word entering execute this cycle |
| flush_o | output | 1 | Taken branch squashes the fetched instruction |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, instructions and operands, 5-bit register fields, a 16-bit offset and a step of 4. With these widths, hand-written instruction words place Rs, Rt and the offset at the fixed bit positions the detector decodes. The 16-bit offset lets a backward branch exercise sign extension of the target. The four-byte step makes the PC arithmetic on stall, flush and sequential cycles visible as exact addresses. A cycle-by-cycle sequence covers Rs and Rt load-use matches, non-load matches, equal and not-equal branches taken and untaken, and a stall that collides with a taken branch.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef struct packed {
    logic mem_to_reg;
    logic reg_write;
  } wb_ctl_t;

  typedef struct packed {
    logic branch;
    logic mem_read;
    logic mem_write;
  } mem_ctl_t;

  typedef struct packed {
    logic       reg_dst;
    logic [1:0] alu_op;
    logic       alu_src;
  } ex_ctl_t;

  // Grouped by consuming stage: write-back on top, execute at the bottom.
  typedef struct packed {
    wb_ctl_t  wb;
    mem_ctl_t mem;
    ex_ctl_t  ex;
  } stage_ctl_t;

  localparam int CTL_W = $bits(stage_ctl_t);

  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_EQ   = 2'b01,
    BR_NE   = 2'b10,
    BR_RSVD = 2'b11
  } br_kind_e;

endpackage

// File: rtl/hz_detect.sv
module hz_detect import hz_pkg::*; #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              ex_mem_read,
  input  logic [REG_W-1:0]  ex_rt,
  input  logic [REG_W-1:0]  dec_rs,
  input  logic [REG_W-1:0]  dec_rt,
  input  logic [1:0]        br_kind,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              load_use,
  output logic              br_taken
);

  localparam int NSRC = 2;

  logic [REG_W-1:0] src [NSRC];
  logic [NSRC-1:0]  hit;

  assign src[0] = dec_rs;
  assign src[1] = dec_rt;

  // One comparator per decode source register.
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign hit[s] = (src[s] == ex_rt);
  end

  assign load_use = ex_mem_read && (|hit);

  logic ops_equal;
  assign ops_equal = (opa == opb);

  always_comb begin
    case (br_kind_e'(br_kind))
      BR_EQ:   br_taken = ops_equal;
      BR_NE:   br_taken = !ops_equal;
      default: br_taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/hz_pc_unit.sv
module hz_pc_unit #(
  parameter int                ADDR_W   = 32,
  parameter int                IMM_W    = 16,
  parameter int                PC_STEP  = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              take,
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  offset,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] pc_inc
);

  localparam int SHIFT = $clog2(PC_STEP);

  logic [ADDR_W-1:0] offset_ext;
  logic [ADDR_W-1:0] target;

  assign offset_ext = {{(ADDR_W-IMM_W){offset[IMM_W-1]}}, offset};
  assign target     = base + (offset_ext << SHIFT);
  assign pc_inc     = pc + ADDR_W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= RESET_PC;
    end else if (we) begin
      pc <= take ? target : pc_inc;
    end
  end

endmodule

// File: rtl/hz_ifid_reg.sv
module hz_ifid_reg #(
  parameter int INSTR_W = 32,
  parameter int ADDR_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               clear,
  input  logic [INSTR_W-1:0] instr_in,
  input  logic [ADDR_W-1:0]  pc4_in,
  output logic [INSTR_W-1:0] instr_q,
  output logic [ADDR_W-1:0]  pc4_q
);

  always_ff @(posedge clk) begin
    if (rst || (we && clear)) begin
      instr_q <= '0;
      pc4_q   <= '0;
    end else if (we) begin
      instr_q <= instr_in;
      pc4_q   <= pc4_in;
    end
  end

endmodule

// File: rtl/hz_idex_ctl.sv
module hz_idex_ctl import hz_pkg::*; #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bubble,
  input  stage_ctl_t       ctl_in,
  input  logic [REG_W-1:0] rt_in,
  output stage_ctl_t       ctl_q,
  output logic [REG_W-1:0] rt_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      rt_q  <= '0;
    end else begin
      ctl_q <= bubble ? stage_ctl_t'('0) : ctl_in;
      rt_q  <= rt_in;
    end
  end

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit import hz_pkg::*; #(
  parameter int                ADDR_W   = 32,
  parameter int                INSTR_W  = 32,
  parameter int                DATA_W   = 32,
  parameter int                REG_W    = 5,
  parameter int                IMM_W    = 16,
  parameter int                PC_STEP  = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] fetch_instr_i,
  input  logic [CTL_W-1:0]   dec_ctl_i,
  input  logic [1:0]         dec_br_kind_i,
  input  logic [DATA_W-1:0]  dec_opa_i,
  input  logic [DATA_W-1:0]  dec_opb_i,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [INSTR_W-1:0] dec_instr_o,
  output logic [ADDR_W-1:0]  dec_pc4_o,
  output logic [CTL_W-1:0]   ex_ctl_o,
  output logic [REG_W-1:0]   ex_rt_o,
  output logic               pc_we_o,
  output logic               ifid_we_o,
  output logic               bubble_o,
  output logic               flush_o
);

  localparam int RT_LSB = IMM_W;
  localparam int RS_LSB = IMM_W + REG_W;
  localparam int OP_LSB = IMM_W + 2 * REG_W;

  logic [REG_W-1:0]  dec_rs;
  logic [REG_W-1:0]  dec_rt;
  logic [IMM_W-1:0]  dec_imm;
  logic              load_use;
  logic              br_taken;
  logic [ADDR_W-1:0] pc_inc;
  stage_ctl_t        ex_ctl;
  logic              unused_opcode;

  assign dec_rs        = dec_instr_o[RS_LSB +: REG_W];
  assign dec_rt        = dec_instr_o[RT_LSB +: REG_W];
  assign dec_imm       = dec_instr_o[IMM_W-1:0];
  assign unused_opcode = ^dec_instr_o[INSTR_W-1:OP_LSB];

  hz_detect #(.REG_W(REG_W), .DATA_W(DATA_W)) detect_i (
    .ex_mem_read (ex_ctl.mem.mem_read),
    .ex_rt       (ex_rt_o),
    .dec_rs      (dec_rs),
    .dec_rt      (dec_rt),
    .br_kind     (dec_br_kind_i),
    .opa         (dec_opa_i),
    .opb         (dec_opb_i),
    .load_use    (load_use),
    .br_taken    (br_taken)
  );

  // A stall freezes the front end; a branch is only honoured without one.
  assign pc_we_o   = !load_use;
  assign ifid_we_o = !load_use;
  assign bubble_o  = load_use;
  assign flush_o   = br_taken && !load_use;

  hz_pc_unit #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)
  ) pc_i (
    .clk    (clk),
    .rst    (rst),
    .we     (pc_we_o),
    .take   (flush_o),
    .base   (dec_pc4_o),
    .offset (dec_imm),
    .pc     (pc_o),
    .pc_inc (pc_inc)
  );

  hz_ifid_reg #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W)) ifid_i (
    .clk      (clk),
    .rst      (rst),
    .we       (ifid_we_o),
    .clear    (flush_o),
    .instr_in (fetch_instr_i),
    .pc4_in   (pc_inc),
    .instr_q  (dec_instr_o),
    .pc4_q    (dec_pc4_o)
  );

  hz_idex_ctl #(.REG_W(REG_W)) idex_i (
    .clk    (clk),
    .rst    (rst),
    .bubble (bubble_o),
    .ctl_in (stage_ctl_t'(dec_ctl_i)),
    .rt_in  (dec_rt),
    .ctl_q  (ex_ctl),
    .rt_q   (ex_rt_o)
  );

  assign ex_ctl_o = ex_ctl;

endmodule

// File: rtl/hz_checker.sv
module hz_checker import hz_pkg::*; #(
  parameter int                ADDR_W   = 32,
  parameter int                INSTR_W  = 32,
  parameter int                REG_W    = 5,
  parameter int                IMM_W    = 16,
  parameter int                PC_STEP  = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  pc_o,
  input logic [INSTR_W-1:0] dec_instr_o,
  input logic [CTL_W-1:0]   ex_ctl_o,
  input logic [REG_W-1:0]   ex_rt_o,
  input logic               pc_we_o,
  input logic               ifid_we_o,
  input logic               bubble_o,
  input logic               flush_o
);

  localparam int MEMRD_BIT = 5;

  logic [REG_W-1:0] chk_rs;
  logic [REG_W-1:0] chk_rt;
  assign chk_rs = dec_instr_o[IMM_W + REG_W +: REG_W];
  assign chk_rt = dec_instr_o[IMM_W +: REG_W];

  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> (pc_o == RESET_PC) && (ex_ctl_o == '0));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (pc_we_o && !flush_o) |=> (pc_o == $past(pc_o) + ADDR_W'(PC_STEP)));

  assert_detect_R3: assert property (@(posedge clk) disable iff (rst)
    (ex_ctl_o[MEMRD_BIT] && ((ex_rt_o == chk_rs) || (ex_rt_o == chk_rt)))
      |-> (bubble_o && !pc_we_o && !ifid_we_o));

  assert_hold_pc_R4: assert property (@(posedge clk) disable iff (rst)
    !pc_we_o |=> $stable(pc_o));

  assert_hold_ifid_R4: assert property (@(posedge clk) disable iff (rst)
    !ifid_we_o |=> $stable(dec_instr_o));

  assert_bubble_zero_R4: assert property (@(posedge clk) disable iff (rst)
    bubble_o |=> (ex_ctl_o == '0));

  assert_single_stall_R4: assert property (@(posedge clk) disable iff (rst)
    bubble_o |=> !bubble_o);

  assert_only_loads_R5: assert property (@(posedge clk) disable iff (rst)
    bubble_o |-> ex_ctl_o[MEMRD_BIT]);

  assert_flush_clear_R7: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> (dec_instr_o == '0));

  assert_stall_wins_R9: assert property (@(posedge clk) disable iff (rst)
    !(flush_o && bubble_o));

endmodule

bind pipe_hazard_unit hz_checker #(
  .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .REG_W(REG_W), .IMM_W(IMM_W),
  .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .pc_o        (pc_o),
  .dec_instr_o (dec_instr_o),
  .ex_ctl_o    (ex_ctl_o),
  .ex_rt_o     (ex_rt_o),
  .pc_we_o     (pc_we_o),
  .ifid_we_o   (ifid_we_o),
  .bubble_o    (bubble_o),
  .flush_o     (flush_o)
);

// File: tb/pipe_hazard_unit_tb_top.sv
module pipe_hazard_unit_tb_top;

  localparam int N = 21;

  // Control words per R10 layout.
  localparam logic [8:0] C_NOP = 9'h000;
  localparam logic [8:0] C_LD  = 9'h1A1; // mem_to_reg, reg_write, mem_read, alu_src
  localparam logic [8:0] C_ADD = 9'h08C; // reg_write, reg_dst, alu_op=10
  localparam logic [8:0] C_BR  = 9'h042; // branch, alu_op=01
  localparam logic [8:0] C_ST  = 9'h011; // mem_write, alu_src

  localparam logic [1:0] K_NONE = 2'b00;
  localparam logic [1:0] K_EQ   = 2'b01;
  localparam logic [1:0] K_NE   = 2'b10;
  localparam logic [1:0] K_RSV  = 2'b11;

  function automatic logic [31:0] mk(input int rs, input int rt, input int imm);
    mk = {6'd0, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  localparam logic [31:0] I0  = mk(1, 2, 0);
  localparam logic [31:0] I1  = mk(2, 3, 0);
  localparam logic [31:0] I2  = mk(4, 5, 0);
  localparam logic [31:0] I3  = mk(6, 7, 3);
  localparam logic [31:0] I4  = mk(8, 9, 0);
  localparam logic [31:0] I5  = mk(1, 10, 0);
  localparam logic [31:0] I6  = mk(10, 11, 2);
  localparam logic [31:0] I7  = mk(12, 13, 0);
  localparam logic [31:0] I8  = mk(3, 4, 5);
  localparam logic [31:0] I9  = mk(12, 13, 16'hFFFE);
  localparam logic [31:0] I10 = mk(14, 15, 0);
  localparam logic [31:0] IX  = mk(1, 20, 0);
  localparam logic [31:0] IY  = mk(21, 20, 0);
  localparam logic [31:0] IW  = mk(2, 3, 0);
  localparam logic [31:0] IZ  = 32'd0;

  typedef struct packed {
    logic [31:0] fetch;
    logic [8:0]  ctl;
    logic [1:0]  br;
    logic [31:0] opa;
    logic [31:0] opb;
    logic        stall;
    logic        flush;
    logic [31:0] pc;
    logic [31:0] instr;
    logic [31:0] pc4;
    logic [8:0]  exctl;
  } vec_t;

  localparam vec_t VEC [N] = '{
    '{I0,  C_NOP, K_NONE, 32'd0, 32'd0, 1'b0, 1'b0, 32'd4,  I0,  32'd4,  C_NOP}, // R2
    '{I1,  C_LD,  K_NONE, 32'd0, 32'd0, 1'b0, 1'b0, 32'd8,  I1,  32'd8,  C_LD},
    '{I2,  C_ADD, K_NONE, 32'd0, 32'd0, 1'b1, 1'b0, 32'd8,  I1,  32'd8,  C_NOP}, // R3 Rs match
    '{I2,  C_ADD, K_NONE, 32'd0, 32'd0, 1'b0, 1'b0, 32'd12, I2,  32'd12, C_ADD}, // R4 one cycle
    '{I3,  C_ADD, K_NONE, 32'd0, 32'd0, 1'b0, 1'b0, 32'd16, I3,  32'd16, C_ADD},
    '{I4,  C_BR,  K_EQ,   32'd5, 32'd5, 1'b0, 1'b1, 32'd28, IZ,  32'd0,  C_BR},  // R7 eq taken
    '{I5,  C_NOP, K_NONE, 32'd0, 32'd0, 1'b0, 1'b0, 32'd32, I5,  32'd32, C_NOP},
    '{I6,  C_LD,  K_NONE, 32'd0, 32'd0, 1'b0, 1'b0, 32'd36, I6,  32'd36, C_LD},
    '{I7,  C_BR,  K_EQ,   32'd1, 32'd1, 1'b1, 1'b0, 32'd36, I6,  32'd36, C_NOP}, // R9 stall wins
    '{I7,  C_BR,  K_NE,   32'd1, 32'd2, 1'b0, 1'b1, 32'd44, IZ,  32'd0,  C_BR},  // R7 ne taken
    '{I8,  C_NOP, K_NONE, 32'd0, 32'd0, 1'b0, 1'b0, 32'd48, I8,  32'd48, C_NOP},
    '{I9,  C_BR,  K_EQ,   32'd1, 32'd2, 1'b0, 1'b0, 32'd52, I9,  32'd52, C_BR},  // R8 untaken
    '{I10, C_BR,  K_NE,   32'd3, 32'd4, 1'b0, 1'b1, 32'd44, IZ,  32'd0,  C_BR},  // R7 backward
    '{IX,  C_NOP, K_NONE, 32'd0, 32'd0, 1'b0, 1'b0, 32'd48, IX,  32'd48, C_NOP},
    '{IY,  C_LD,  K_NONE, 32'd0, 32'd0, 1'b0, 1'b0, 32'd52, IY,  32'd52, C_LD},
    '{IZ,  C_ADD, K_NONE, 32'd0, 32'd0, 1'b1, 1'b0, 32'd52, IY,  32'd52, C_NOP}, // R3 Rt match
    '{IZ,  C_ADD, K_NONE, 32'd0, 32'd0, 1'b0, 1'b0, 32'd56, IZ,  32'd56, C_ADD},
    '{IW,  C_LD,  K_NONE, 32'd0, 32'd0, 1'b0, 1'b0, 32'd60, IW,  32'd60, C_LD},
    '{IZ,  C_ADD, K_NONE, 32'd0, 32'd0, 1'b0, 1'b0, 32'd64, IZ,  32'd64, C_ADD}, // R5 no match
    '{IZ,  C_ST,  K_NONE, 32'd0, 32'd0, 1'b0, 1'b0, 32'd68, IZ,  32'd68, C_ST},
    '{IZ,  C_NOP, K_NONE, 32'd0, 32'd0, 1'b0, 1'b0, 32'd72, IZ,  32'd72, C_NOP}  // R5 store match
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_instr = '0;
  logic [8:0]  dec_ctl = '0;
  logic [1:0]  br_kind = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [31:0] pc, dec_instr, dec_pc4;
  logic [8:0]  ex_ctl;
  logic [4:0]  ex_rt;
  logic        pc_we, ifid_we, bubble, flush;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pipe_hazard_unit dut_i (
    .clk           (clk),
    .rst           (rst),
    .fetch_instr_i (fetch_instr),
    .dec_ctl_i     (dec_ctl),
    .dec_br_kind_i (br_kind),
    .dec_opa_i     (opa),
    .dec_opb_i     (opb),
    .pc_o          (pc),
    .dec_instr_o   (dec_instr),
    .dec_pc4_o     (dec_pc4),
    .ex_ctl_o      (ex_ctl),
    .ex_rt_o       (ex_rt),
    .pc_we_o       (pc_we),
    .ifid_we_o     (ifid_we),
    .bubble_o      (bubble),
    .flush_o       (flush)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", pc, 32'd0);
    chk("R1 reset ifid instr", dec_instr, 32'd0);
    chk("R1 reset ifid pc4", dec_pc4, 32'd0);
    chk("R1 reset ex ctl", {23'd0, ex_ctl}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < N; i++) begin
      fetch_instr = VEC[i].fetch;
      dec_ctl     = VEC[i].ctl;
      br_kind     = VEC[i].br;
      opa         = VEC[i].opa;
      opb         = VEC[i].opb;
      #1;
      chk($sformatf("R3/R5 bubble row %0d", i), {31'd0, bubble}, {31'd0, VEC[i].stall});
      chk($sformatf("R3 pc_we row %0d", i), {31'd0, pc_we}, {31'd0, !VEC[i].stall});
      chk($sformatf("R3 ifid_we row %0d", i), {31'd0, ifid_we}, {31'd0, !VEC[i].stall});
      chk($sformatf("R6/R9 flush row %0d", i), {31'd0, flush}, {31'd0, VEC[i].flush});
      @(posedge clk);
      #1;
      chk($sformatf("R2/R4/R7/R8 pc row %0d", i), pc, VEC[i].pc);
      chk($sformatf("R2/R4/R7 ifid instr row %0d", i), dec_instr, VEC[i].instr);
      chk($sformatf("R2/R7 ifid pc4 row %0d", i), dec_pc4, VEC[i].pc4);
      chk($sformatf("R10/R4 ex ctl row %0d", i), {23'd0, ex_ctl}, {23'd0, VEC[i].exctl});
      @(negedge clk);
    end

    // R1: reset in mid-run with busy inputs.
    rst = 1'b1;
    fetch_instr = I3;
    dec_ctl = C_LD;
    @(posedge clk);
    #1;
    chk("R1 mid reset pc", pc, 32'd0);
    chk("R1 mid reset ifid", dec_instr, 32'd0);
    chk("R1 mid reset ex ctl", {23'd0, ex_ctl}, 32'd0);
    chk("R1 mid reset ex rt", {27'd0, ex_rt}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R6: reserved branch kind with equal operands is never taken.
    fetch_instr = I0;
    dec_ctl = C_BR;
    br_kind = K_RSV;
    opa = 32'd9;
    opb = 32'd9;
    #1;
    chk("R6 reserved kind flush", {31'd0, flush}, 32'd0);
    @(posedge clk);
    #1;
    chk("R6 reserved kind pc", pc, 32'd4);
    chk("R6 reserved kind ifid", dec_instr, I0);
    chk("R10 branch ctl passes", {23'd0, ex_ctl}, {23'd0, C_BR});
    @(negedge clk);

    // R6: branch kind none with unequal operands is not taken either.
    fetch_instr = I1;
    dec_ctl = C_NOP;
    br_kind = K_NONE;
    opa = 32'd1;
    opb = 32'd2;
    #1;
    chk("R6 none kind flush", {31'd0, flush}, 32'd0);
    @(posedge clk);
    #1;
    chk("R8 none kind pc", pc, 32'd8);
    finish_run();
  end

  initial begin
    #(8 * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule